// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a memory-mapped watchdog peripheral on an APB-style register port. A 32-bit down-counter runs from a programmable start value. When it reaches zero for the first time, an interrupt is raised and the counter starts again from the start value. If the counter reaches zero a second time while that interrupt is still pending, the block requests a system reset, provided reset requests are enabled. The reset request is a level that stays high until the block itself is reset.

Software services the watchdog by writing the interrupt-clear register. That write drops the interrupt and restarts the count, so no second expiry occurs. All writes except writes to the lock register are ignored unless the block has first been unlocked with a 32-bit magic key. Reads are always allowed and return the data without wait states.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the lock register (offset 0xC00) reads 1, the control register (0x008) reads 0, the start-value register (0x000) reads 0xFFFFFFFF, the status register (0x014) reads 0, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 makes bit 0 of that register read 0 (unlocked). Writing the same key again leaves it unlocked. Writing any other value makes bit 0 read 1 (locked).
- R3: While the block is locked, writes to offsets 0x000, 0x008 and 0x00C have no effect.
- R4: In the control register, bit 1 runs the counter and bit 0 enables reset requests. Bits 31:2 always read zero. A write that sets bit 1 while it is clear loads the counter with the start value, and the count port shows that value one cycle later.
- R5: While bit 1 is set, the counter at offset 0x004 falls by one on each clock. Clearing bit 1 freezes the count.
- R6: On the clock after the count reads zero, `irq_o` rises, the count reloads from the start value, and offset 0x014 reads 1.
- R7: A zero count with `irq_o` already high and control bit 0 set raises `rst_req_o` on the next clock. `rst_req_o` then stays high until block reset, even if the interrupt is cleared.
- R8: With control bit 0 clear, a second expiry leaves `rst_req_o` low and `irq_o` high.
- R9: Writing a value with bit 0 set to offset 0x00C while unlocked clears `irq_o` and reloads the count from the start value on the same clock. Clearing on every first expiry keeps `rst_req_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Active-low asynchronous block reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase; a write takes effect on the edge where psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, driven combinationally from paddr |
| irq_o | output | 1 | Pending first-expiry interrupt |
| rst_req_o | output | 1 | Sticky reset request after the second expiry |

## Verification
A register write lands on the single clock edge of its access phase, and the count reads back the start value right after that edge. With a start value L, the first expiry shows on `irq_o` L+1 edges after the start write, and the second expiry shows on `rst_req_o` a further L+1 edges later. The bench samples on falling edges, so it counts exactly that many edges before each check. It also samples one edge early to show that the output is still low. Reads are combinational and are taken a step after a falling edge, so a read never races a register update.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam logic [11:0] OFS_START = 12'h000;
  localparam logic [11:0] OFS_COUNT = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_ICLR  = 12'h00C;
  localparam logic [11:0] OFS_STAT  = 12'h014;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;
  localparam logic [31:0] OPEN_KEY  = 32'h1ACC_E551;

  typedef struct packed {
    logic run;
    logic rst_en;
  } ctrl_t;
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              irq,
  output logic [CNT_W-1:0]  start_val,
  output ctrl_t             ctrl,
  output logic              start_p,
  output logic              clr_p,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(OFS_ICLR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(OFS_LOCK);
  localparam logic [DATA_W-1:0] KEY     = DATA_W'(OPEN_KEY);

  logic wr, wr_ok;

  assign wr    = psel & penable & pwrite;
  assign wr_ok = wr & ~locked;

  // The lock register accepts writes in every state; the others only when open.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b1;
      start_val <= '1;
      ctrl      <= '0;
    end else begin
      if (wr && paddr == A_LOCK) locked <= (pwdata != KEY);
      if (wr_ok && paddr == A_START) start_val <= pwdata[CNT_W-1:0];
      if (wr_ok && paddr == A_CTRL) begin
        ctrl.run    <= pwdata[1];
        ctrl.rst_en <= pwdata[0];
      end
    end
  end

  assign start_p = wr_ok && paddr == A_CTRL && pwdata[1] && !ctrl.run;
  assign clr_p   = wr_ok && paddr == A_ICLR && pwdata[0];

  always_comb begin
    prdata = '0;
    case (paddr)
      A_START: prdata[CNT_W-1:0] = start_val;
      A_COUNT: prdata[CNT_W-1:0] = cnt;
      A_CTRL:  prdata[1:0]       = {ctrl.run, ctrl.rst_en};
      A_STAT:  prdata[0]         = irq;
      A_LOCK:  prdata[0]         = locked;
      default: prdata            = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] start_val,
  input  logic             start_p,
  input  logic             clr_p,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             rst_req
);
  logic expire;

  // A clear or a start in the same cycle as a zero count cancels that expiry.
  assign expire = run && !start_p && !clr_p && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (start_p || clr_p)  cnt <= start_val;
      else if (run) begin
        if (cnt == '0)       cnt <= start_val;
        else                 cnt <= cnt - 1'b1;
      end

      if (clr_p)             irq <= 1'b0;
      else if (expire)       irq <= 1'b1;

      if (expire && irq && rst_en) rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] cnt, start_val;
  ctrl_t            ctrl;
  logic             start_p, clr_p, locked, irq, rst_req;

  keyed_wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt(cnt), .irq(irq),
    .start_val(start_val), .ctrl(ctrl), .start_p(start_p), .clr_p(clr_p),
    .locked(locked)
  );

  keyed_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .rst_en(ctrl.rst_en),
    .start_val(start_val), .start_p(start_p), .clr_p(clr_p),
    .cnt(cnt), .irq(irq), .rst_req(rst_req)
  );

  assign irq_o     = irq;
  assign rst_req_o = rst_req;
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic [CNT_W-1:0] start_val,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             rst_en,
  input logic             start_p,
  input logic             clr_p,
  input logic             irq,
  input logic             rst_req
);
  p_locked_start_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(start_val));

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !start_p && !clr_p) |=> cnt == $past(cnt) - 1'b1);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_p && !clr_p) |=> $stable(cnt));

  p_irq_from_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt) == '0);

  p_rst_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_rst_after_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(irq) && $past(rst_en)));

  p_rst_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_en && !rst_req) |=> !rst_req);

  p_clear_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> !irq);
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .start_val(start_val), .cnt(cnt),
  .run(ctrl.run), .rst_en(ctrl.rst_en), .start_p(start_p), .clr_p(clr_p),
  .irq(irq), .rst_req(rst_req)
);

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam logic [11:0] A_ST = 12'h000, A_CN = 12'h004, A_CT = 12'h008,
                          A_IC = 12'h00C, A_SS = 12'h014, A_LK = 12'hC00;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        irq_o, rst_req_o;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // {write, requirement, address, data, expected read}
  localparam int NV = 18;
  localparam logic [80:0] VEC [0:NV-1] = '{
    {1'b0, 4'd1, A_LK, 32'h0,          32'h1},
    {1'b0, 4'd1, A_ST, 32'h0,          32'hFFFF_FFFF},
    {1'b0, 4'd1, A_CT, 32'h0,          32'h0},
    {1'b0, 4'd1, A_SS, 32'h0,          32'h0},
    {1'b1, 4'd3, A_ST, 32'h10,         32'h0},
    {1'b0, 4'd3, A_ST, 32'h0,          32'hFFFF_FFFF},
    {1'b1, 4'd2, A_LK, KEY,            32'h0},
    {1'b0, 4'd2, A_LK, 32'h0,          32'h0},
    {1'b1, 4'd2, A_LK, KEY,            32'h0},
    {1'b0, 4'd2, A_LK, 32'h0,          32'h0},
    {1'b1, 4'd4, A_ST, 32'h20,         32'h0},
    {1'b0, 4'd4, A_ST, 32'h0,          32'h20},
    {1'b1, 4'd4, A_CT, 32'hFFFF_FFFC,  32'h0},
    {1'b0, 4'd4, A_CT, 32'h0,          32'h0},
    {1'b1, 4'd2, A_LK, 32'h1234,       32'h0},
    {1'b0, 4'd2, A_LK, 32'h0,          32'h1},
    {1'b1, 4'd3, A_CT, 32'h3,          32'h0},
    {1'b0, 4'd3, A_CT, 32'h0,          32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    paddr = a; psel = 1'b1; pwrite = 1'b0;
    #1;
    d = prdata;
    psel = 1'b0;
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    steps(2);
    rst_n = 1'b1;
    steps(1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    do_reset();
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R1 rst_req after reset", {31'b0, rst_req_o}, 32'h0);

    // Register table: R1 reset values, R2 lock key, R3 locked writes, R4 reserved bits.
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], v);
        chk($sformatf("R%0d table entry %0d", VEC[i][79:76], i), v, VEC[i][31:0]);
      end
    end

    // Two-stage expiry with reset enabled: start value 5.
    do_reset();
    wr(A_LK, KEY);
    wr(A_ST, 32'd5);
    wr(A_CT, 32'h3);
    rd(A_CN, v);  chk("R4 start loads count", v, 32'd5);
    steps(3);
    rd(A_CN, v);  chk("R5 decrement", v, 32'd2);
    steps(2);
    chk("R6 irq not yet", {31'b0, irq_o}, 32'h0);
    steps(1);
    chk("R6 irq on first expiry", {31'b0, irq_o}, 32'h1);
    rd(A_CN, v);  chk("R6 reload on expiry", v, 32'd5);
    rd(A_SS, v);  chk("R6 status pending", v, 32'h1);
    steps(5);
    chk("R7 reset not yet", {31'b0, rst_req_o}, 32'h0);
    steps(1);
    chk("R7 reset on second expiry", {31'b0, rst_req_o}, 32'h1);
    wr(A_IC, 32'h1);
    chk("R9 clear drops irq", {31'b0, irq_o}, 32'h0);
    steps(20);
    chk("R7 reset held", {31'b0, rst_req_o}, 32'h1);

    // Reset disabled: start value 3.
    do_reset();
    wr(A_LK, KEY);
    wr(A_ST, 32'd3);
    wr(A_CT, 32'h2);
    steps(4);
    chk("R6 irq at L+1", {31'b0, irq_o}, 32'h1);
    steps(4);
    chk("R8 no reset when disabled", {31'b0, rst_req_o}, 32'h0);
    chk("R8 irq stays", {31'b0, irq_o}, 32'h1);
    wr(A_IC, 32'h1);
    chk("R9 clear drops irq", {31'b0, irq_o}, 32'h0);
    rd(A_CN, v);  chk("R9 clear reloads", v, 32'd3);
    wr(A_CT, 32'h0);
    rd(A_CN, v);
    steps(5);
    rd(A_CN, v2); chk("R5 count frozen", v2, v);
    chk("R5 frozen no irq", {31'b0, irq_o}, 32'h0);

    // Locked: clear and start-value writes ignored.
    wr(A_CT, 32'h2);
    wr(A_LK, 32'h0);
    steps(6);
    chk("R6 irq while locked", {31'b0, irq_o}, 32'h1);
    wr(A_IC, 32'h1);
    chk("R3 locked clear ignored", {31'b0, irq_o}, 32'h1);
    wr(A_ST, 32'd9);
    rd(A_ST, v);  chk("R3 locked start write ignored", v, 32'd3);

    // Servicing each first expiry keeps reset away.
    do_reset();
    wr(A_LK, KEY);
    wr(A_ST, 32'd4);
    wr(A_CT, 32'h3);
    for (int k = 0; k < 5; k++) begin
      for (int t = 0; t < 12 && !irq_o; t++) steps(1);
      chk("R9 serviced expiry seen", {31'b0, irq_o}, 32'h1);
      wr(A_IC, 32'h1);
    end
    chk("R9 serviced no reset", {31'b0, rst_req_o}, 32'h0);

    summary();
    $finish;
  end
endmodule